// File: doc/BRIEF.md
# Priority Memory Chip-Select Decoder

This block turns a bus address into chip selects for a banked code memory, one scratch RAM, an internal I/O window and a peripheral I/O window. Every window is placed by configuration inputs: a base and a length for each code bank and each I/O window, and a base for the RAM, whose length follows from the bus width. The four code banks share one bank capacity of 8, 16 or 32 KB. In 16-bit mode the address counts 16-bit words, so every capacity in address units is half its byte count.

Where RAM or an I/O window sits on top of code space, the RAM or I/O select wins, and that part of the code bank cannot be reached. The block also checks the configuration itself. It raises one error flag when code windows overlap each other, when RAM and the I/O windows overlap each other, or when a code window is longer than a bank. Selects and the error flag are registered, so they appear one clock after the inputs.

Top module: `csel_decoder`

## Requirements
- R1: During and right after reset, all selects and `cfg_err` are 0.
- R2: Outputs are registered. They reflect the inputs sampled at the previous rising clock edge. Code bank i is hit when `code_len[i]` is nonzero and `code_base[i] <= bus_addr < code_base[i] + code_len[i]`, where the sum is computed without wrap.
- R3: While `bus_strobe` is 0, all selects are 0 on the next cycle.
- R4: At most one of `sel_code[3:0]`, `sel_ram`, `sel_io` and `sel_pio` is 1 in any cycle.
- R5: The RAM window starts at `ram_base`. It is 2048 addresses long when `wide_bus` = 0 and 1024 when `wide_bus` = 1.
- R6: A hit on RAM, internal I/O or enabled peripheral I/O blocks every code-bank select for that address.
- R7: The peripheral window can be selected, and can take part in overlap checks, only while `pio_enable` = 1.
- R8: `cfg_err` is raised when any `code_len[i]` exceeds the bank span. The span is 8192, 16384 or 32768 for `blk_size` 0, 1 or 2, and 32768 for 3. The span is halved when `wide_bus` = 1.
- R9: `cfg_err` is raised when two code windows with nonzero lengths share at least one address. Windows that only touch end to end do not raise it.
- R10: `cfg_err` is raised when RAM, internal I/O and enabled peripheral I/O windows share an address. Overlap of any of them with code space is legal.
- R11: Under a faulty configuration the fixed order RAM > internal I/O > peripheral I/O > code holds, and among code banks the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_strobe | input | 1 | Address valid |
| bus_addr | input | ADDR_W | Byte address (8-bit mode) or word address (16-bit mode) |
| wide_bus | input | 1 | 1 selects the 16-bit organization |
| blk_size | input | 2 | Code bank capacity code |
| code_base | input | NCODE x ADDR_W | Base address of each code window |
| code_len | input | NCODE x ADDR_W | Length of each code window, 0 = disabled |
| ram_base | input | ADDR_W | Base address of the RAM window |
| io_base | input | ADDR_W | Base address of the internal I/O window |
| io_len | input | ADDR_W | Length of the internal I/O window |
| pio_base | input | ADDR_W | Base address of the peripheral I/O window |
| pio_len | input | ADDR_W | Length of the peripheral I/O window |
| pio_enable | input | 1 | Shared port is in peripheral I/O mode |
| sel_code | output | NCODE | Code bank selects |
| sel_ram | output | 1 | RAM select |
| sel_io | output | 1 | Internal I/O select |
| sel_pio | output | 1 | Peripheral I/O select |
| cfg_err | output | 1 | Forbidden configuration flag |

## Verification
Two results can fall in the same cycle and on the same address: a code-bank hit and a RAM or I/O hit that must override it. A configuration error can also be raised while the decode still has to produce a clean select. The random phase aims addresses at the edges of deliberately stacked windows and draws lengths around the bank span. One legal select and a set error flag are then expected together. Each cycle's whole output vector is compared against a bench model that applies the priority order and the overlap rules independently.

// File: rtl/csel_pkg.sv
package csel_pkg;

  typedef enum logic [1:0] {
    BLK_SMALL = 2'd0,
    BLK_MID   = 2'd1,
    BLK_LARGE = 2'd2,
    BLK_ALT   = 2'd3
  } blk_size_e;

  // Half-open window test with the end computed one bit wider (no wrap).
  function automatic logic in_win(input logic [31:0] a, input logic [31:0] base,
                                  input logic [31:0] len);
    logic [32:0] lim;
    lim = {1'b0, base} + {1'b0, len};
    return (len != 32'd0) && ({1'b0, a} >= {1'b0, base}) && ({1'b0, a} < lim);
  endfunction

  // Two nonempty windows share an address.
  function automatic logic win_ovl(input logic [31:0] b1, input logic [31:0] l1,
                                   input logic [31:0] b2, input logic [31:0] l2);
    logic [32:0] e1;
    logic [32:0] e2;
    e1 = {1'b0, b1} + {1'b0, l1};
    e2 = {1'b0, b2} + {1'b0, l2};
    return (l1 != 32'd0) && (l2 != 32'd0) && ({1'b0, b1} < e2) && ({1'b0, b2} < e1);
  endfunction

  // Bank span in address units.
  function automatic logic [31:0] bank_span(input blk_size_e sz, input logic wide,
                                            input logic [31:0] min_bytes);
    logic [31:0] bytes;
    unique case (sz)
      BLK_SMALL: bytes = min_bytes;
      BLK_MID:   bytes = min_bytes << 1;
      default:   bytes = min_bytes << 2;
    endcase
    return wide ? (bytes >> 1) : bytes;
  endfunction

  function automatic logic [31:0] ram_span(input logic wide, input logic [31:0] ram_bytes);
    return wide ? (ram_bytes >> 1) : ram_bytes;
  endfunction

endpackage

// File: rtl/csel_window.sv
module csel_window #(
  parameter int unsigned AW = 17
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  input  logic          en,
  output logic          hit
);
  import csel_pkg::*;

  assign hit = en && in_win(32'(addr), 32'(base), 32'(len));

endmodule

// File: rtl/csel_cfg_check.sv
module csel_cfg_check #(
  parameter int unsigned AW    = 17,
  parameter int unsigned NCODE = 4
) (
  input  logic [NCODE-1:0][AW-1:0] code_base,
  input  logic [NCODE-1:0][AW-1:0] code_len,
  input  logic [31:0]              span,
  input  logic [AW-1:0]            ram_base,
  input  logic [AW-1:0]            ram_len,
  input  logic [AW-1:0]            io_base,
  input  logic [AW-1:0]            io_len,
  input  logic [AW-1:0]            pio_base,
  input  logic [AW-1:0]            pio_len,
  input  logic                     pio_en,
  output logic                     span_viol,
  output logic                     code_ovl,
  output logic                     aux_ovl
);
  import csel_pkg::*;

  localparam int unsigned NPAIR = NCODE * NCODE;

  logic [NCODE-1:0] len_big;
  logic [NPAIR-1:0] pair_ovl;
  logic [AW-1:0]    pio_len_eff;

  generate
    for (genvar i = 0; i < NCODE; i++) begin : g_span
      assign len_big[i] = 32'(code_len[i]) > span;
    end
    for (genvar i = 0; i < NCODE; i++) begin : g_row
      for (genvar j = 0; j < NCODE; j++) begin : g_col
        if (j > i) begin : g_chk
          assign pair_ovl[i*NCODE+j] = win_ovl(32'(code_base[i]), 32'(code_len[i]),
                                               32'(code_base[j]), 32'(code_len[j]));
        end else begin : g_nochk
          assign pair_ovl[i*NCODE+j] = 1'b0;
        end
      end
    end
  endgenerate

  assign pio_len_eff = pio_en ? pio_len : '0;
  assign span_viol   = |len_big;
  assign code_ovl    = |pair_ovl;
  assign aux_ovl     = win_ovl(32'(ram_base), 32'(ram_len), 32'(io_base), 32'(io_len))
                     | win_ovl(32'(ram_base), 32'(ram_len), 32'(pio_base), 32'(pio_len_eff))
                     | win_ovl(32'(io_base), 32'(io_len), 32'(pio_base), 32'(pio_len_eff));

endmodule

// File: rtl/csel_arbiter.sv
module csel_arbiter #(
  parameter int unsigned NCODE = 4
) (
  input  logic             strobe,
  input  logic [NCODE-1:0] code_hit,
  input  logic             ram_hit,
  input  logic             io_hit,
  input  logic             pio_hit,
  output logic [NCODE-1:0] code_sel,
  output logic             ram_sel,
  output logic             io_sel,
  output logic             pio_sel
);
  logic [NCODE-1:0] lowest;
  logic             aux_any;

  // Isolate the lowest set bit: lowest index wins among code banks.
  assign lowest  = code_hit & (~code_hit + 1'b1);
  assign aux_any = ram_hit | io_hit | pio_hit;

  always_comb begin
    ram_sel  = strobe && ram_hit;
    io_sel   = strobe && !ram_hit && io_hit;
    pio_sel  = strobe && !ram_hit && !io_hit && pio_hit;
    code_sel = (strobe && !aux_any) ? lowest : '0;
  end

endmodule

// File: rtl/csel_decoder.sv
module csel_decoder #(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned NCODE     = 4,
  parameter int unsigned MIN_BANK  = 8192,
  parameter int unsigned RAM_BYTES = 2048
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_strobe,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         wide_bus,
  input  logic [1:0]                   blk_size,
  input  logic [NCODE-1:0][ADDR_W-1:0] code_base,
  input  logic [NCODE-1:0][ADDR_W-1:0] code_len,
  input  logic [ADDR_W-1:0]            ram_base,
  input  logic [ADDR_W-1:0]            io_base,
  input  logic [ADDR_W-1:0]            io_len,
  input  logic [ADDR_W-1:0]            pio_base,
  input  logic [ADDR_W-1:0]            pio_len,
  input  logic                         pio_enable,
  output logic [NCODE-1:0]             sel_code,
  output logic                         sel_ram,
  output logic                         sel_io,
  output logic                         sel_pio,
  output logic                         cfg_err
);
  import csel_pkg::*;

  localparam int unsigned NSEL = NCODE + 3;

  logic [31:0]      span;
  logic [ADDR_W-1:0] ram_len;
  logic [NCODE-1:0] code_hit;
  logic             ram_hit, io_hit, pio_hit;
  logic [NCODE-1:0] code_nx;
  logic             ram_nx, io_nx, pio_nx;
  logic             span_viol, code_ovl, aux_ovl;

  assign span    = bank_span(blk_size_e'(blk_size), wide_bus, 32'(MIN_BANK));
  assign ram_len = ADDR_W'(ram_span(wide_bus, 32'(RAM_BYTES)));

  generate
    for (genvar i = 0; i < NCODE; i++) begin : g_code
      csel_window #(.AW(ADDR_W)) u_win (
        .addr(bus_addr), .base(code_base[i]), .len(code_len[i]), .en(1'b1), .hit(code_hit[i])
      );
    end
  endgenerate

  csel_window #(.AW(ADDR_W)) u_ram (
    .addr(bus_addr), .base(ram_base), .len(ram_len), .en(1'b1), .hit(ram_hit)
  );
  csel_window #(.AW(ADDR_W)) u_io (
    .addr(bus_addr), .base(io_base), .len(io_len), .en(1'b1), .hit(io_hit)
  );
  csel_window #(.AW(ADDR_W)) u_pio (
    .addr(bus_addr), .base(pio_base), .len(pio_len), .en(pio_enable), .hit(pio_hit)
  );

  csel_arbiter #(.NCODE(NCODE)) u_arb (
    .strobe(bus_strobe), .code_hit(code_hit), .ram_hit(ram_hit), .io_hit(io_hit),
    .pio_hit(pio_hit), .code_sel(code_nx), .ram_sel(ram_nx), .io_sel(io_nx), .pio_sel(pio_nx)
  );

  csel_cfg_check #(.AW(ADDR_W), .NCODE(NCODE)) u_chk (
    .code_base(code_base), .code_len(code_len), .span(span),
    .ram_base(ram_base), .ram_len(ram_len), .io_base(io_base), .io_len(io_len),
    .pio_base(pio_base), .pio_len(pio_len), .pio_en(pio_enable),
    .span_viol(span_viol), .code_ovl(code_ovl), .aux_ovl(aux_ovl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_code <= '0;
      sel_ram  <= 1'b0;
      sel_io   <= 1'b0;
      sel_pio  <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      sel_code <= code_nx;
      sel_ram  <= ram_nx;
      sel_io   <= io_nx;
      sel_pio  <= pio_nx;
      cfg_err  <= span_viol | code_ovl | aux_ovl;
    end
  end

  logic [NSEL-1:0] sel_all;
  assign sel_all = {sel_code, sel_ram, sel_io, sel_pio};

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_all)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strobe |=> (sel_all == '0)); // R3
  AST_RAM_OVER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && ram_hit) |=> (sel_ram && sel_code == '0)); // R6
  AST_IO_OVER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && io_hit) |=> (sel_code == '0)); // R6
  AST_PIO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !pio_enable |=> !sel_pio); // R7
  AST_SPAN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    span_viol |=> cfg_err); // R8
  AST_CODE_OVL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    code_ovl |=> cfg_err); // R9
  AST_AUX_OVL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    aux_ovl |=> cfg_err); // R10

endmodule

// File: tb/csel_decoder_tb.sv
module csel_decoder_tb;
  localparam int CLK_P = 10;
  localparam int AW    = 17;
  localparam int NC    = 4;
  localparam longint AMASK = (64'd1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_strobe = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic wide_bus = 1'b0;
  logic [1:0] blk_size = 2'd0;
  logic [NC-1:0][AW-1:0] code_base = '0;
  logic [NC-1:0][AW-1:0] code_len = '0;
  logic [AW-1:0] ram_base = '0, io_base = '0, io_len = '0, pio_base = '0, pio_len = '0;
  logic pio_enable = 1'b0;
  logic [NC-1:0] sel_code;
  logic sel_ram, sel_io, sel_pio, cfg_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  csel_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_addr(bus_addr),
    .wide_bus(wide_bus), .blk_size(blk_size), .code_base(code_base), .code_len(code_len),
    .ram_base(ram_base), .io_base(io_base), .io_len(io_len), .pio_base(pio_base),
    .pio_len(pio_len), .pio_enable(pio_enable), .sel_code(sel_code), .sel_ram(sel_ram),
    .sel_io(sel_io), .sel_pio(sel_pio), .cfg_err(cfg_err)
  );

  function automatic bit inside_w(longint a, longint b, longint l);
    return (l > 0) && (a >= b) && (a < b + l);
  endfunction

  function automatic bit share(longint b1, longint l1, longint b2, longint l2);
    if (l1 == 0 || l2 == 0) return 0;
    return !((b1 + l1 <= b2) || (b2 + l2 <= b1));
  endfunction

  function automatic longint span_m();
    longint s;
    s = (blk_size == 2'd0) ? 8192 : (blk_size == 2'd1) ? 16384 : 32768;
    return wide_bus ? s / 2 : s;
  endfunction

  // Expected {code[3:0], ram, io, pio, err}
  function automatic logic [7:0] model();
    logic [7:0] r;
    longint rl, pl;
    r = '0;
    rl = wide_bus ? 1024 : 2048;
    pl = pio_enable ? longint'(pio_len) : 0;
    if (bus_strobe) begin
      if (inside_w(bus_addr, ram_base, rl)) r[3] = 1;
      else if (inside_w(bus_addr, io_base, io_len)) r[2] = 1;
      else if (inside_w(bus_addr, pio_base, pl)) r[1] = 1;
      else begin
        for (int i = 0; i < NC; i++)
          if (inside_w(bus_addr, code_base[i], code_len[i])) begin
            r[4+i] = 1;
            break;
          end
      end
    end
    for (int i = 0; i < NC; i++) begin
      if (longint'(code_len[i]) > span_m()) r[0] = 1;
      for (int j = i + 1; j < NC; j++)
        if (share(code_base[i], code_len[i], code_base[j], code_len[j])) r[0] = 1;
    end
    if (share(ram_base, rl, io_base, io_len) || share(ram_base, rl, pio_base, pl) ||
        share(io_base, io_len, pio_base, pl)) r[0] = 1;
    return r;
  endfunction

  function automatic logic [7:0] got();
    return {sel_code, sel_ram, sel_io, sel_pio, cfg_err};
  endfunction

  task automatic cmp(string tag, logic [7:0] exp);
    checks++;
    if (got() !== exp || $countones(got() & 8'hFE) > 1) begin
      errors++;
      $display("FAIL %s: got=%b expected=%b addr=%h", tag, got(), exp, bus_addr);
    end
  endtask

  // Inputs were set after a falling edge; capture at the next rising edge.
  task automatic step(string tag);
    logic [7:0] e;
    e = model();
    @(posedge clk);
    #1;
    cmp(tag, e);
    @(negedge clk);
  endtask

  task automatic clear_cfg();
    code_base = '0; code_len = '0; ram_base = '0; io_base = '0; io_len = '0;
    pio_base = '0; pio_len = '0; pio_enable = 0; wide_bus = 0; blk_size = 0;
  endtask

  task automatic std_cfg();
    clear_cfg();
    blk_size = 2'd0;
    for (int i = 0; i < NC; i++) begin
      code_base[i] = AW'(i * 8192);
      code_len[i]  = AW'(8192);
    end
    ram_base = AW'(17'h01000); io_base = AW'(17'h05000); io_len = AW'(256);
    pio_base = AW'(17'h06000); pio_len = AW'(128);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #(CLK_P * 2);
    #1;
    cmp("R1 reset", 8'h00);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    std_cfg();
    bus_strobe = 1;
    // R2: window edges of bank 1
    bus_addr = AW'(8192);  step("R2 base");
    bus_addr = AW'(16383); step("R2 last");
    bus_addr = AW'(16384); step("R2 next bank");
    // R2: output holds until the edge
    bus_addr = AW'(100);
    #1;
    checks++;
    if (sel_code !== 4'b0100) begin
      errors++;
      $display("FAIL R2 latency: got=%b expected=%b", sel_code, 4'b0100);
    end
    step("R2 after edge");

    // R3 strobe low
    bus_strobe = 0; bus_addr = AW'(8192); step("R3 idle");
    bus_strobe = 1;

    // R5 RAM boundaries in both modes, R6 override
    bus_addr = AW'(17'h01000 + 2047); step("R5 ram last 8b");
    bus_addr = AW'(17'h01000 + 2048); step("R5 ram end 8b");
    wide_bus = 1;
    for (int i = 0; i < NC; i++) code_len[i] = AW'(4096);
    bus_addr = AW'(17'h01000 + 1023); step("R5 ram last 16b");
    bus_addr = AW'(17'h01000 + 1024); step("R5 ram end 16b");
    wide_bus = 0;
    for (int i = 0; i < NC; i++) code_len[i] = AW'(8192);
    bus_addr = AW'(17'h05010); step("R6 io over code");

    // R7 peripheral window gating
    bus_addr = AW'(17'h06005); pio_enable = 0; step("R7 pio off");
    pio_enable = 1; step("R7 pio on");

    // R8 span limits
    code_len[0] = AW'(8193); step("R8 over span");
    code_len[0] = AW'(8192); blk_size = 2'd3; code_len[0] = AW'(20000); step("R8 code 3");
    wide_bus = 1; step("R8 halved span");
    wide_bus = 0; blk_size = 0; code_len[0] = AW'(8192); step("R8 clean");

    // R9 code window overlap
    code_base[1] = AW'(8191); step("R9 overlap one");
    code_base[1] = AW'(8192); step("R9 touching");

    // R10 aux overlap, R11 priority under fault
    io_base = AW'(17'h01400); bus_addr = AW'(17'h01450); step("R10 R11 ram over io");
    io_base = AW'(17'h05000);
    pio_base = AW'(17'h050F0); bus_addr = AW'(17'h050F8); step("R10 R11 io over pio");
    pio_enable = 0; step("R10 pio disabled no err");
    pio_enable = 1; pio_base = AW'(17'h06000);
    code_base[2] = AW'(100); code_len[2] = AW'(50); bus_addr = AW'(120); step("R11 low bank wins");

    // Random phase
    for (int t = 0; t < 3000; t++) begin
      clear_cfg();
      wide_bus = $urandom % 2;
      blk_size = 2'($urandom);
      for (int i = 0; i < NC; i++) begin
        code_base[i] = AW'(($urandom % 32) * 4096);
        code_len[i]  = AW'(($urandom % 4 == 0) ? 0 : $urandom % 20000);
      end
      ram_base = AW'(($urandom % 32) * 4096 + $urandom % 1024);
      io_base  = AW'(($urandom % 32) * 4096 + $urandom % 2048);
      io_len   = AW'($urandom % 600);
      pio_base = AW'(($urandom % 32) * 4096 + $urandom % 2048);
      pio_len  = AW'($urandom % 300);
      pio_enable = $urandom % 2;
      bus_strobe = ($urandom % 8) != 0;
      case ($urandom % 5)
        0: bus_addr = AW'((longint'(ram_base) + $urandom % 2100) & AMASK);
        1: bus_addr = AW'((longint'(io_base) + $urandom % 700) & AMASK);
        2: bus_addr = AW'((longint'(pio_base) + $urandom % 400) & AMASK);
        3: bus_addr = AW'((longint'(code_base[$urandom % NC]) + $urandom % 20000) & AMASK);
        default: bus_addr = AW'($urandom);
      endcase
      step("R4 R6 R8 R9 R10 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule